// File: doc/BRIEF.md
# Transmit Byte Queue with Watermark Events

This block holds bytes that software has written for transmission until a serial shifter takes them. Bytes arrive on a valid/ready write stream and leave, oldest first, on a valid/ready read stream that the shifter drives. The block reports its occupancy, full and empty flags, and three event signals for a separate interrupt block:
- a watermark state that rises when the occupancy reaches a programmable threshold;
- a one-cycle pulse when the queue runs dry or is flushed;
- a one-cycle overflow pulse when a byte has to be thrown away.

The write stream does not stall its producer. `wr_ready` is low only while the queue is full. A byte offered while `wr_ready` is low is dropped, and `ovf_err` pulses. The read stream has ordinary back-pressure: `rd_valid` stays high while data is held, and a byte is consumed only on a cycle where both `rd_valid` and `rd_ready` are high. A `flush` pulse discards every stored byte. Level, flags and events all change on the clock edge that follows the handshake that causes them.

Top module: `tx_fifo_wm`

## Requirements
- R1: While `rst_n` is low, `level` is 0, `rd_valid` is 0, `wr_ready` is 1, and `wm_evt`, `empty_evt` and `ovf_err` are all 0.
- R2: Bytes leave on `rd_data` in the order they were accepted. `rd_data` shows the oldest stored byte whenever `rd_valid` is high.
- R3: A byte offered while the queue holds DEPTH bytes is dropped. One cycle later `ovf_err` is high for one cycle, and the stored bytes and `level` are unchanged.
- R4: When a push and a pop are both accepted in the same cycle, `level` stays the same and both transfers take effect.
- R5: `wr_ready` is low exactly when `level` equals DEPTH (32 by default).
- R6: `rd_valid` is high exactly when `level` is nonzero.
- R7: After an accepted push that leaves `level` at or above `wm_level`, `wm_evt` is 1.
- R8: After an accepted pop that leaves `level` below `wm_level`, `wm_evt` is 0. `wm_evt` is also 0 whenever `level` has become 0.
- R9: `empty_evt` is high for one cycle after a flush, or after a pop (with no push) that brings `level` to 0.
- R10: When `flush` is high, `level` is 0 after the next edge, all stored bytes are discarded, and a write offered in that cycle is neither stored nor flagged as overflow.
- R11: `level` equals the number of stored bytes. It changes on the edge after each accepted transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Byte offered on the write stream |
| wr_data | input | DW | Byte to store |
| wr_ready | output | 1 | Queue has room; low only when full |
| rd_valid | output | 1 | A byte is available to the shifter |
| rd_data | output | DW | Oldest stored byte |
| rd_ready | input | 1 | Shifter takes the byte |
| flush | input | 1 | Discard all stored bytes |
| wm_level | input | LW | Watermark threshold |
| level | output | LW | Number of stored bytes |
| wm_evt | output | 1 | Watermark state for the interrupt block |
| empty_evt | output | 1 | Pulse: queue became empty |
| ovf_err | output | 1 | Pulse: an offered byte was dropped |

## Verification
The bench targets four cases:
- **Offers against a full queue.** A design that overwrote the oldest entry or wrapped its count would corrupt the byte order or show a level of 0.
- **Push and pop in the same cycle, at the threshold and just off it.** A design that resolved these in the wrong order would lose a byte or flip `wm_evt`.
- **Pops that stay above the threshold, and a final drain to zero.** A design that cleared the watermark on every pop, or never pulsed `empty_evt`, would be caught here.
- **A flush with a write in the same cycle.** This exposes a design that stores the late byte or reports an overflow for it.

A long run of pseudo-random traffic with a changing threshold then compares every byte that leaves against the scoreboard.

// File: rtl/txbuf_pkg.sv
package txbuf_pkg;

  // one cycle's worth of accepted transfers, shared by the sub-blocks
  typedef struct packed {
    logic push;
    logic pop;
    logic flush;
  } txb_xfer_t;

endpackage

// File: rtl/txbuf_store.sv
module txbuf_store #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  txbuf_pkg::txb_xfer_t xf,
  input  logic [DW-1:0]        wdata,
  output logic [DW-1:0]        rdata
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned PW = AW + 1;

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wptr_q, rptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
    end else if (xf.flush) begin
      wptr_q <= '0;
      rptr_q <= '0;
    end else begin
      if (xf.push) wptr_q <= wptr_q + 1'b1;
      if (xf.pop)  rptr_q <= rptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (xf.push) mem[wptr_q[AW-1:0]] <= wdata;
  end

  assign rdata = mem[rptr_q[AW-1:0]];

endmodule

// File: rtl/txbuf_count.sv
module txbuf_count #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned LW    = $clog2(DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  txbuf_pkg::txb_xfer_t xf,
  output logic [LW-1:0]        level,
  output logic [LW-1:0]        level_nx,
  output logic                 full,
  output logic                 empty
);
  localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH);

  logic [LW-1:0] level_q;

  always_comb begin
    level_nx = level_q;
    if (xf.flush)                 level_nx = '0;
    else if (xf.push && !xf.pop)  level_nx = level_q + 1'b1;
    else if (xf.pop && !xf.push)  level_nx = level_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= '0;
    else        level_q <= level_nx;
  end

  assign level = level_q;
  assign full  = (level_q == FULL_LVL);
  assign empty = (level_q == '0);

endmodule

// File: rtl/txbuf_events.sv
module txbuf_events #(
  parameter int unsigned LW = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  txbuf_pkg::txb_xfer_t xf,
  input  logic [LW-1:0]        level_nx,
  input  logic [LW-1:0]        wm_level,
  input  logic                 drop,
  output logic                 wm_evt,
  output logic                 empty_evt,
  output logic                 ovf_err
);
  logic wm_q, mt_q, ovf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wm_q  <= 1'b0;
      mt_q  <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      ovf_q <= drop;
      mt_q  <= xf.flush | (xf.pop & ~xf.push & (level_nx == '0));
      if (xf.flush || level_nx == '0)
        wm_q <= 1'b0;
      else if (xf.push && level_nx >= wm_level)
        wm_q <= 1'b1;
      else if (xf.pop && level_nx < wm_level)
        wm_q <= 1'b0;
    end
  end

  assign wm_evt    = wm_q;
  assign empty_evt = mt_q;
  assign ovf_err   = ovf_q;

endmodule

// File: rtl/tx_fifo_wm.sv
module tx_fifo_wm #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 32,
  parameter int unsigned LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic [DW-1:0] wr_data,
  output logic          wr_ready,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  input  logic          rd_ready,
  input  logic          flush,
  input  logic [LW-1:0] wm_level,
  output logic [LW-1:0] level,
  output logic          wm_evt,
  output logic          empty_evt,
  output logic          ovf_err
);
  txbuf_pkg::txb_xfer_t xf;
  logic          full, empty, drop;
  logic [LW-1:0] level_nx;

  assign wr_ready = ~full;
  assign rd_valid = ~empty;
  assign xf.push  = wr_valid & ~full & ~flush;
  assign xf.pop   = rd_ready & ~empty & ~flush;
  assign xf.flush = flush;
  assign drop     = wr_valid & full & ~flush;

  txbuf_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .xf(xf), .wdata(wr_data), .rdata(rd_data)
  );

  txbuf_count #(.DEPTH(DEPTH), .LW(LW)) u_count (
    .clk(clk), .rst_n(rst_n), .xf(xf), .level(level), .level_nx(level_nx),
    .full(full), .empty(empty)
  );

  txbuf_events #(.LW(LW)) u_events (
    .clk(clk), .rst_n(rst_n), .xf(xf), .level_nx(level_nx),
    .wm_level(wm_level), .drop(drop), .wm_evt(wm_evt),
    .empty_evt(empty_evt), .ovf_err(ovf_err)
  );

endmodule

// File: rtl/tx_fifo_wm_chk.sv
module tx_fifo_wm_chk #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned LW    = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic          rd_valid,
  input logic          rd_ready,
  input logic          flush,
  input logic [LW-1:0] wm_level,
  input logic [LW-1:0] level,
  input logic          wm_evt,
  input logic          empty_evt,
  input logic          ovf_err
);
  a_r11_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, level} <= (LW+1)'(DEPTH));

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(wr_valid && !wr_ready && !flush)) |-> ovf_err);

  a_r3_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(!wr_ready && !(rd_valid && rd_ready) && !flush)) |-> !wr_ready);

  a_r10_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(flush)) |-> (level == '0 && empty_evt && !wm_evt));

  a_r4_level_steady: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(wr_valid && wr_ready && rd_valid && rd_ready && !flush))
      |-> level == $past(level));

  a_r7_wm_set: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(wr_valid && wr_ready && !(rd_valid && rd_ready) && !flush
                            && ({1'b0, level} + 1'b1 >= {1'b0, wm_level}))) |-> wm_evt);

  a_r9_pulse_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    empty_evt |-> (level == '0 && !rd_valid));

endmodule

bind tx_fifo_wm tx_fifo_wm_chk #(.DEPTH(DEPTH), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .flush(flush), .wm_level(wm_level),
  .level(level), .wm_evt(wm_evt), .empty_evt(empty_evt), .ovf_err(ovf_err)
);

// File: tb/tx_fifo_wm_bench.sv
`timescale 1ns/1ps
module tx_fifo_wm_bench;
  localparam int DW = 8;
  localparam int DEPTH = 32;
  localparam int LW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0, rd_ready = 1'b0, flush = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [LW-1:0] wm_level = '0;
  logic wr_ready, rd_valid, wm_evt, empty_evt, ovf_err;
  logic [DW-1:0] rd_data;
  logic [LW-1:0] level;

  always #2.5 clk = ~clk;

  tx_fifo_wm u_tx_fifo_wm (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_ready(wr_ready), .rd_valid(rd_valid), .rd_data(rd_data),
    .rd_ready(rd_ready), .flush(flush), .wm_level(wm_level), .level(level),
    .wm_evt(wm_evt), .empty_evt(empty_evt), .ovf_err(ovf_err)
  );

  int errs = 0;
  int checks = 0;
  logic [DW-1:0] sb_q[$];
  int  mlvl = 0;
  bit  mwm = 1'b0;
  logic [7:0] lfsr = 8'hA5;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // driver: apply one cycle, predict, then check after the edge
  task automatic cyc(input bit v, input logic [DW-1:0] d, input bit r,
                     input bit fl, input int wm);
    bit acc_push, acc_pop, exp_ovf, exp_mt;
    int nl;
    wr_valid = v; wr_data = d; rd_ready = r; flush = fl; wm_level = LW'(wm);
    #0.1;
    chk(wr_ready == (mlvl < DEPTH), "R5", "wr_ready", wr_ready, mlvl < DEPTH);
    chk(rd_valid == (mlvl != 0), "R6", "rd_valid", rd_valid, mlvl != 0);
    acc_push = v && (mlvl < DEPTH) && !fl;
    acc_pop  = r && (mlvl > 0) && !fl;
    exp_ovf  = v && (mlvl == DEPTH) && !fl;
    // monitor: the byte taken this cycle must be the scoreboard head
    if (acc_pop) begin
      chk(rd_data == sb_q[0], "R2", "rd_data", rd_data, sb_q[0]);
      void'(sb_q.pop_front());
    end
    if (acc_push) sb_q.push_back(d);
    if (fl) sb_q.delete();
    nl = fl ? 0 : mlvl + int'(acc_push) - int'(acc_pop);
    exp_mt = fl || (acc_pop && !acc_push && nl == 0);
    if (fl || nl == 0) mwm = 1'b0;
    else if (acc_push && nl >= wm) mwm = 1'b1;
    else if (acc_pop && nl < wm) mwm = 1'b0;
    mlvl = nl;
    @(posedge clk); #1;
    chk(int'(level) == mlvl, fl ? "R10" : (acc_push && acc_pop ? "R4" : "R11"),
        "level", level, mlvl);
    chk(wm_evt == mwm, mwm ? "R7" : "R8", "wm_evt", wm_evt, mwm);
    chk(empty_evt == exp_mt, "R9", "empty_evt", empty_evt, exp_mt);
    chk(ovf_err == exp_ovf, fl ? "R10" : "R3", "ovf_err", ovf_err, exp_ovf);
  endtask

  initial begin
    #(5.0 * 200000);
    errs++;
    checks++;
    $display("FAIL watchdog expired level=%0d expected=done", level);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset values
    chk(level == 0, "R1", "level", level, 0);
    chk(rd_valid == 0, "R1", "rd_valid", rd_valid, 0);
    chk(wr_ready == 1, "R1", "wr_ready", wr_ready, 1);
    chk(wm_evt == 0, "R1", "wm_evt", wm_evt, 0);
    chk(empty_evt == 0 && ovf_err == 0, "R1", "pulses", empty_evt | ovf_err, 0);
    rst_n = 1'b1;
    @(posedge clk); #1;

    // R7: rise at threshold 4
    for (int i = 0; i < 6; i++) cyc(1, 8'h10 + 8'(i), 0, 0, 4);
    // R8: pops staying above/at threshold keep it, dropping below clears
    for (int i = 0; i < 3; i++) cyc(0, 0, 1, 0, 4);
    // R4: push and pop together around the threshold
    cyc(1, 8'h40, 1, 0, 3);
    cyc(1, 8'h41, 1, 0, 4);
    // R5, R3: fill to full then offer extra bytes
    while (mlvl < DEPTH) cyc(1, 8'(8'h80 + mlvl), 0, 0, 8);
    for (int i = 0; i < 3; i++) cyc(1, 8'hEE, 0, 0, 8);
    // full queue with a pop and an offer in the same cycle: offer dropped
    cyc(1, 8'hEF, 1, 0, 8);
    cyc(1, 8'h55, 1, 0, 8);
    // R9, R6: drain to zero, then pop attempts while empty
    while (mlvl > 0) cyc(0, 0, 1, 0, 8);
    cyc(0, 0, 1, 0, 8);
    // R10: flush with a concurrent write
    for (int i = 0; i < 5; i++) cyc(1, 8'h20 + 8'(i), 0, 0, 2);
    cyc(1, 8'hAA, 1, 1, 2);
    cyc(0, 0, 1, 0, 2);
    // flush while full also suppresses overflow
    while (mlvl < DEPTH) cyc(1, 8'(mlvl), 0, 0, 32);
    cyc(1, 8'hBB, 0, 1, 32);
    // mixed traffic with changing threshold
    for (int i = 0; i < 600; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      cyc(lfsr[0] | lfsr[3], lfsr ^ 8'(i), lfsr[1] & (lfsr[2] | lfsr[6]),
          (lfsr == 8'h17), (i / 100) * 6);
    end
    while (mlvl > 0) cyc(0, 0, 1, 0, 1);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule